// File: doc/BRIEF.md
# Transmit Stuck-Dominant Guard

This block sits between a bus protocol controller and the line driver of a differential field bus transceiver. It watches the transmit data line coming from the controller, where a low level means dominant. If that line gets stuck low through a software or hardware fault, the node would otherwise hold the shared bus dominant and block every other node.

The transmit line first passes through a two-flop synchronizer, which resets to the recessive level. Each synchronized high-to-low transition starts a timer. The timer advances only on cycles where the tick enable is high, so the block's clock frequency does not set the time-out. If the line is still low after a parameterized number of ticks, the block drops the driver enable and raises a time-out flag, and the driver releases the bus to recessive. Every synchronized low-to-high transition clears the timer. It also lifts a time-out, so recovery needs only a recessive level on the transmit line.

The time-out length, counted in ticks, is chosen so that at the system's tick rate it falls between 0.3 ms and 6 ms, with 2 ms typical. The lower bound keeps the longest legal run of dominant bits, eleven of them, from tripping the guard at any bit rate down to 40 kbit/s.

Top module: `txd_stuck_guard`

## Requirements
- R1: After reset, `drv_en` is 1 and `stuck_flag` is 0, and the synchronizer holds the recessive (high) level.
- R2: A dominant period that ends (TXD back high) before TIMEOUT_TICKS ticks have been counted leaves `drv_en` at 1 throughout.
- R3: If TXD stays low from a falling edge until TIMEOUT_TICKS ticks have been counted, `drv_en` goes to 0 and `stuck_flag` goes to 1 on the clock edge that counts the last tick. Neither changes on an edge where `tick_en` is 0.
- R4: A rising edge on TXD clears the tick count, so the next dominant period starts counting again from zero.
- R5: Once timed out, `drv_en` stays 0 while TXD stays low, whatever ticks arrive.
- R6: After a time-out, a rising TXD restores `drv_en` to 1 and clears `stuck_flag` on the third clock edge after the input changes. That is 60 ns at 50 MHz, well within 1 us.
- R7: Ticks that arrive while TXD is high and no dominant period is being timed have no effect: `drv_en` stays 1.
- R8: `stuck_flag` is always the inverse of `drv_en`.
- R9: TIMEOUT_TICKS times the tick period lies between 0.3 ms and 6 ms.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd_in | input | 1 | Transmit data from the protocol controller; low means dominant |
| tick_en | input | 1 | One-cycle pulse that advances the dominant timer |
| drv_en | output | 1 | Transmitter driver enable; 0 forces the bus recessive |
| stuck_flag | output | 1 | High while the transmitter is held off by a time-out |

## Verification
The hardest state to reach is the boundary between a long legal dominant period and a time-out. The count has to sit exactly one tick short of the limit and then either get one more tick or a rising edge. The bench drives `tick_en` as single pulses it counts itself, so it can stop at TIMEOUT_TICKS-1 ticks or run on to TIMEOUT_TICKS. It also breaks a long low period just before the limit and then starts it again, which shows that the count restarts rather than accumulates.

// File: rtl/txd_stuck_guard.sv
module txd_stuck_guard #(
  parameter int TIMEOUT_TICKS = 2000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_in,
  input  logic tick_en,
  output logic drv_en,
  output logic stuck_flag
);

  localparam int CW = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   timing_q;
  logic                   off_q;
  logic [CW-1:0]          cnt_q;
  logic                   txd_s;
  logic                   fall, rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], txd_in};

  assign txd_s = sync_q[SYNC_STAGES-1];
  assign fall  = prev_q & ~txd_s;
  assign rise  = ~prev_q & txd_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= txd_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timing_q <= 1'b0;
      off_q    <= 1'b0;
      cnt_q    <= '0;
    end else if (rise) begin
      timing_q <= 1'b0;
      off_q    <= 1'b0;
      cnt_q    <= '0;
    end else if (fall) begin
      timing_q <= 1'b1;
      cnt_q    <= '0;
    end else if (timing_q && tick_en) begin
      if (cnt_q == LAST) begin
        timing_q <= 1'b0;
        off_q    <= 1'b1;
        cnt_q    <= '0;
      end else begin
        cnt_q    <= cnt_q + 1'b1;
      end
    end
  end

  assign drv_en     = ~off_q;
  assign stuck_flag = off_q;

  // R3: the driver is only switched off on a counted tick
  a_r3_drop_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_en) |-> $past(tick_en));

  // R3: a time-out only happens while TXD is dominant
  a_r3_drop_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_en) |-> !prev_q);

  // R5: a time-out holds until a rising edge
  a_r5_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q && !rise) |=> !drv_en);

  // R6: a rising edge always restores the driver
  a_r6_recover: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (drv_en && !stuck_flag));

  // R4: the count never passes its limit
  a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R7: with TXD recessive and no timing, the driver stays on
  a_r7_idle_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (txd_s && prev_q && !off_q) |=> drv_en);

  // R8: the flag always mirrors the disabled state
  always_comb if (rst_n) a_r8_flag_mirror: assert (stuck_flag == !drv_en);

endmodule

// File: tb/txd_stuck_guard_test.sv
module txd_stuck_guard_test;
  localparam int LIMIT     = 2000;
  localparam int TICK_CYC  = 50;
  localparam int CLK_NS    = 20;

  logic clk = 0, rst_n = 0, txd = 1, tick = 0;
  logic drv_en, stuck_flag;
  int checks = 0, failures = 0;

  txd_stuck_guard #(.TIMEOUT_TICKS(LIMIT), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .txd_in(txd), .tick_en(tick),
    .drv_en(drv_en), .stuck_flag(stuck_flag));

  always #10 clk = ~clk;

  task automatic check(input string req, input logic act_en, input logic exp_en);
    checks++;
    if (act_en !== exp_en || stuck_flag !== !exp_en) begin
      failures++;
      $display("FAIL %s drv_en=%b stuck_flag=%b expected drv_en=%b stuck_flag=%b",
               req, act_en, stuck_flag, exp_en, !exp_en);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
    end
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic go_low;
    @(negedge clk) txd = 0;
    settle(4);
  endtask

  task automatic go_high;
    @(negedge clk) txd = 1;
    settle(4);
  endtask

  task automatic t_reset;
    check("R1 reset", drv_en, 1'b1);
  endtask

  task automatic t_bounds;
    longint t_ns = longint'(LIMIT) * TICK_CYC * CLK_NS;
    checks++;
    if (t_ns < 300_000 || t_ns > 6_000_000) begin
      failures++;
      $display("FAIL R9 timeout_ns=%0d expected 300000..6000000", t_ns);
    end
  endtask

  task automatic t_short_dominant;
    go_low;
    ticks(LIMIT - 1);
    check("R2 one tick short", drv_en, 1'b1);
    go_high;
    check("R2 after release", drv_en, 1'b1);
  endtask

  task automatic t_restart;
    go_low;
    ticks(LIMIT - 1);
    go_high;
    go_low;
    ticks(LIMIT - 1);
    check("R4 count restarted", drv_en, 1'b1);
    go_high;
  endtask

  task automatic t_timeout_and_recover;
    go_low;
    ticks(LIMIT - 1);
    check("R3 before last tick", drv_en, 1'b1);
    settle(5);
    check("R3 no change without tick", drv_en, 1'b1);
    ticks(1);
    check("R3 timed out", drv_en, 1'b0);
    ticks(3 * LIMIT / 2);
    check("R5 held off", drv_en, 1'b0);
    @(negedge clk) txd = 1;
    @(negedge clk);
    check("R6 not yet at edge 1", drv_en, 1'b0);
    @(negedge clk);
    check("R6 not yet at edge 2", drv_en, 1'b0);
    @(negedge clk);
    check("R6 restored at edge 3", drv_en, 1'b1);
  endtask

  task automatic t_idle_ticks;
    ticks(2 * LIMIT);
    check("R7 idle ticks ignored", drv_en, 1'b1);
  endtask

  task automatic t_second_timeout;
    go_low;
    ticks(LIMIT);
    check("R3 second timeout", drv_en, 1'b0);
    go_high;
    check("R6 second recovery", drv_en, 1'b1);
  endtask

  initial begin
    fork
      begin
        settle(3);
        @(negedge clk) rst_n = 1;
        settle(2);
        t_reset;
        t_bounds;
        t_short_dominant;
        t_restart;
        t_timeout_and_recover;
        t_idle_ticks;
        t_second_timeout;
      end
      begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule